// File: doc/BRIEF.md
# Converter Sample Buffer with Auto-Addressed Memory Transfer

This block sits between a data converter and a dedicated working memory. Samples arrive with a valid strobe and enter a small first-in first-out store. By default a transfer engine empties that store into the memory, one word per clock. The engine writes to an address formed from a fixed base plus a word offset that advances after each write. As an alternative, the host turns the engine off and takes samples one at a time from a read register.

A host-loaded sample budget limits how many samples are captured. Samples that arrive while the store is full are discarded, and an overflow flag records the loss. The working memory has a single port. A host or DMA read is therefore passed through the block. A read that meets an engine write in the same cycle is refused: it returns a fixed guard word and raises an access-violation flag.

Top module: `sxb_top`

## Requirements
- R1: After reset the offset is 0, the sample budget is 0, both flags are 0, the read register holds 0 and no memory write is issued.
- R2: A sample is accepted when `run_en` and `smp_valid` are high, the budget is non-zero and the store is not full. Each accepted sample lowers `cnt_left` by one. A `cnt_wr` pulse loads the budget.
- R3: The store holds 64 samples. When it holds 64 at the start of a cycle, an arriving sample is discarded and does not use up budget. `ovf_flag` is set in the next cycle. The stored samples are unchanged.
- R4: `ovf_flag` and `acc_flag` stay at 1 until a one-cycle clear pulse (`ovf_clr` or `acc_clr`) is given. A set in the same cycle as a clear wins.
- R5: With `xfer_off` low, every cycle in which the store is non-empty issues exactly one write (`mem_we` high). The write carries the oldest sample, so writes come out in arrival order.
- R6: The write byte address `mem_addr` equals MEM_BASE (default 0x0C000) plus twice `ofs_cur`. `ofs_cur` rises by one after each write.
- R7: `ofs_cur` is 15 bits wide. After a write at 0x7FFF (byte offset 0xFFFE) it wraps to 0.
- R8: An `ofs_wr` pulse loads `ofs_cur` from `ofs_wdata`. A load takes priority over the increment of a write in the same cycle.
- R9: With `xfer_off` high, no writes are issued. A `dat_rd` pulse pops the oldest sample into `dat_rdata` in the next cycle. A pulse while the store is empty leaves `dat_rdata` and the store unchanged.
- R10: Samples already stored keep draining after `run_en` falls or the budget reaches 0. This holds in both modes.
- R11: In a cycle with `hst_re` high and `mem_we` high, the block returns `hst_rdata` = 0x3FFF, holds `mem_re` low, and sets `acc_flag` in the next cycle. Otherwise `mem_re` follows `hst_re`, `mem_addr` follows `hst_addr` and `hst_rdata` follows `mem_rdata`.
- R12: With `xfer_off` low, `dat_rd` has no effect: `dat_rdata` keeps its value.
- R13: With a budget of 0, arriving samples are neither stored nor counted as overflow.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset |
| smp_valid | input | 1 | Converter sample strobe |
| smp_data | input | 16 | Converter sample |
| run_en | input | 1 | Capture enable |
| xfer_off | input | 1 | 1 = host reads samples itself, 0 = transfer engine runs |
| ofs_wr | input | 1 | Load word offset |
| ofs_wdata | input | 15 | Word offset to load |
| ofs_cur | output | 15 | Current word offset |
| cnt_wr | input | 1 | Load sample budget |
| cnt_wdata | input | 10 | Sample budget to load |
| cnt_left | output | 10 | Remaining sample budget |
| dat_rd | input | 1 | Host pop of the data register |
| dat_rdata | output | 16 | Last sample popped by the host |
| ovf_flag | output | 1 | Sticky overflow flag |
| ovf_clr | input | 1 | Clear overflow flag |
| acc_flag | output | 1 | Sticky access-violation flag |
| acc_clr | input | 1 | Clear access-violation flag |
| mem_we | output | 1 | Memory write enable (engine busy) |
| mem_re | output | 1 | Memory read enable |
| mem_addr | output | 20 | Shared memory byte address |
| mem_wdata | output | 16 | Memory write data |
| mem_rdata | input | 16 | Memory read data |
| hst_re | input | 1 | Host/DMA read request |
| hst_addr | input | 20 | Host/DMA read byte address |
| hst_rdata | output | 16 | Read data returned to host/DMA |

## Verification
An engine write and a host memory read can fall in the same cycle. Both want the single memory port. The bench provokes this by raising `hst_re` in exactly the cycle after a sample is captured, which is the cycle in which the engine writes it. In that cycle the monitor requires the guard word, no memory read and the write address on the port. It then requires `acc_flag` one cycle later. An unblocked read without a concurrent write is judged against the pass-through path. This separates the two outcomes.

// File: rtl/sxb_pkg.sv
package sxb_pkg;
  // word returned to a reader that collides with an engine write
  localparam logic [15:0] GUARD_WORD = 16'h3FFF;

  // combined sticky-flag update: a set beats a clear
  function automatic logic sticky_next(input logic cur, input logic set, input logic clr);
    return set | (cur & ~clr);
  endfunction
endpackage

// File: rtl/sxb_fifo.sv
module sxb_fifo #(
  parameter int unsigned DATA_W = 16,
  parameter int unsigned DEPTH  = 64
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              push,
  input  logic              pop,
  input  logic [DATA_W-1:0] wdata,
  output logic [DATA_W-1:0] head,
  output logic              empty,
  output logic              full
);
  localparam int unsigned PW = (DEPTH > 1) ? $clog2(DEPTH) : 1;
  localparam int unsigned LW = $clog2(DEPTH + 1);

  logic [DATA_W-1:0] store [DEPTH];
  logic [PW-1:0]     wr_ptr, rd_ptr;
  logic [LW-1:0]     level;
  logic              do_push, do_pop;

  function automatic logic [PW-1:0] ptr_adv(input logic [PW-1:0] p);
    return (p == PW'(DEPTH - 1)) ? '0 : p + PW'(1);
  endfunction

  assign empty   = (level == '0);
  assign full    = (level == LW'(DEPTH));
  assign do_push = push & ~full;
  assign do_pop  = pop & ~empty;
  assign head    = store[rd_ptr];

  always_ff @(posedge clk) begin
    if (do_push) store[wr_ptr] <= wdata;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wr_ptr <= '0;
      rd_ptr <= '0;
      level  <= '0;
    end else begin
      if (do_push) wr_ptr <= ptr_adv(wr_ptr);
      if (do_pop)  rd_ptr <= ptr_adv(rd_ptr);
      case ({do_push, do_pop})
        2'b10:   level <= level + LW'(1);
        2'b01:   level <= level - LW'(1);
        default: level <= level;
      endcase
    end
  end

  // R3: occupancy never exceeds the store depth
  a_r3_level_bound: assert property (@(posedge clk) disable iff (!rst_n)
    level <= LW'(DEPTH));

  // R3: a push into a full store leaves the occupancy unchanged unless a pop happens
  a_r3_full_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (full && !pop) |=> full);
endmodule

// File: rtl/sxb_addr_gen.sv
module sxb_addr_gen #(
  parameter int unsigned OFS_W  = 15,
  parameter int unsigned CNT_W  = 10,
  parameter int unsigned ADDR_W = 20,
  parameter logic [ADDR_W-1:0] MEM_BASE = 20'h0C000
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              step,
  input  logic              ofs_ld,
  input  logic [OFS_W-1:0]  ofs_ld_val,
  input  logic              take,
  input  logic              cnt_ld,
  input  logic [CNT_W-1:0]  cnt_ld_val,
  output logic [OFS_W-1:0]  ofs,
  output logic [ADDR_W-1:0] waddr,
  output logic [CNT_W-1:0]  cnt,
  output logic              cnt_zero
);
  // byte address of a word offset inside the working memory
  function automatic logic [ADDR_W-1:0] byte_addr(input logic [OFS_W-1:0] o);
    return MEM_BASE + ADDR_W'({o, 1'b0});
  endfunction

  assign waddr    = byte_addr(ofs);
  assign cnt_zero = (cnt == '0);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ofs <= '0;
      cnt <= '0;
    end else begin
      if (ofs_ld)    ofs <= ofs_ld_val;
      else if (step) ofs <= ofs + OFS_W'(1);
      if (cnt_ld)    cnt <= cnt_ld_val;
      else if (take) cnt <= cnt - CNT_W'(1);
    end
  end

  // R6/R7: each write without a load advances the offset by one, wrapping
  a_r6_ofs_step: assert property (@(posedge clk) disable iff (!rst_n)
    (step && !ofs_ld) |=> ofs == $past(ofs) + OFS_W'(1));

  // R8: a load wins over the increment
  a_r8_load_wins: assert property (@(posedge clk) disable iff (!rst_n)
    ofs_ld |=> ofs == $past(ofs_ld_val));

  // R2: an accepted sample consumes one unit of budget
  a_r2_cnt_dec: assert property (@(posedge clk) disable iff (!rst_n)
    (take && !cnt_ld) |=> cnt == $past(cnt) - CNT_W'(1));

  // R13: nothing is taken once the budget is spent
  a_r13_no_take_at_zero: assert property (@(posedge clk) disable iff (!rst_n)
    cnt_zero |-> !take);
endmodule

// File: rtl/sxb_rd_guard.sv
module sxb_rd_guard #(
  parameter int unsigned DATA_W = 16,
  parameter int unsigned ADDR_W = 20
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              busy,
  input  logic [ADDR_W-1:0] waddr,
  input  logic              hst_re,
  input  logic [ADDR_W-1:0] hst_addr,
  input  logic [DATA_W-1:0] mem_rdata,
  output logic              mem_re,
  output logic [ADDR_W-1:0] mem_addr,
  output logic [DATA_W-1:0] hst_rdata,
  output logic              violation
);
  import sxb_pkg::*;

  assign violation = busy & hst_re;
  assign mem_re    = hst_re & ~busy;
  assign mem_addr  = busy ? waddr : hst_addr;
  assign hst_rdata = violation ? DATA_W'(GUARD_WORD) : mem_rdata;

  // R11: a colliding read gets the guard word and never reaches the memory
  a_r11_guard: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && hst_re) |-> (hst_rdata == DATA_W'(GUARD_WORD) && !mem_re && mem_addr == waddr));
endmodule

// File: rtl/sxb_top.sv
module sxb_top #(
  parameter int unsigned DATA_W = 16,
  parameter int unsigned DEPTH  = 64,
  parameter int unsigned OFS_W  = 15,
  parameter int unsigned CNT_W  = 10,
  parameter int unsigned ADDR_W = 20,
  parameter logic [ADDR_W-1:0] MEM_BASE = 20'h0C000
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              smp_valid,
  input  logic [DATA_W-1:0] smp_data,
  input  logic              run_en,
  input  logic              xfer_off,
  input  logic              ofs_wr,
  input  logic [OFS_W-1:0]  ofs_wdata,
  output logic [OFS_W-1:0]  ofs_cur,
  input  logic              cnt_wr,
  input  logic [CNT_W-1:0]  cnt_wdata,
  output logic [CNT_W-1:0]  cnt_left,
  input  logic              dat_rd,
  output logic [DATA_W-1:0] dat_rdata,
  output logic              ovf_flag,
  input  logic              ovf_clr,
  output logic              acc_flag,
  input  logic              acc_clr,
  output logic              mem_we,
  output logic              mem_re,
  output logic [ADDR_W-1:0] mem_addr,
  output logic [DATA_W-1:0] mem_wdata,
  input  logic [DATA_W-1:0] mem_rdata,
  input  logic              hst_re,
  input  logic [ADDR_W-1:0] hst_addr,
  output logic [DATA_W-1:0] hst_rdata
);
  import sxb_pkg::*;

  logic [DATA_W-1:0] head;
  logic [ADDR_W-1:0] waddr;
  logic fifo_empty, fifo_full, cnt_zero;
  logic take_req, accept, drop, xfer_go, host_pop, pop, violation;

  // named internal events
  assign take_req = run_en & smp_valid & ~cnt_zero;
  assign accept   = take_req & ~fifo_full;
  assign drop     = take_req & fifo_full;
  assign xfer_go  = ~xfer_off & ~fifo_empty;
  assign host_pop = xfer_off & dat_rd & ~fifo_empty;
  assign pop      = xfer_go | host_pop;

  assign mem_we    = xfer_go;
  assign mem_wdata = head;

  sxb_fifo #(.DATA_W(DATA_W), .DEPTH(DEPTH)) u_fifo (
    .clk(clk), .rst_n(rst_n), .push(accept), .pop(pop), .wdata(smp_data),
    .head(head), .empty(fifo_empty), .full(fifo_full)
  );

  sxb_addr_gen #(.OFS_W(OFS_W), .CNT_W(CNT_W), .ADDR_W(ADDR_W), .MEM_BASE(MEM_BASE)) u_addr (
    .clk(clk), .rst_n(rst_n), .step(xfer_go), .ofs_ld(ofs_wr), .ofs_ld_val(ofs_wdata),
    .take(accept), .cnt_ld(cnt_wr), .cnt_ld_val(cnt_wdata),
    .ofs(ofs_cur), .waddr(waddr), .cnt(cnt_left), .cnt_zero(cnt_zero)
  );

  sxb_rd_guard #(.DATA_W(DATA_W), .ADDR_W(ADDR_W)) u_guard (
    .clk(clk), .rst_n(rst_n), .busy(xfer_go), .waddr(waddr), .hst_re(hst_re),
    .hst_addr(hst_addr), .mem_rdata(mem_rdata), .mem_re(mem_re), .mem_addr(mem_addr),
    .hst_rdata(hst_rdata), .violation(violation)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      dat_rdata <= '0;
      ovf_flag  <= 1'b0;
      acc_flag  <= 1'b0;
    end else begin
      if (host_pop) dat_rdata <= head;
      ovf_flag <= sticky_next(ovf_flag, drop, ovf_clr);
      acc_flag <= sticky_next(acc_flag, violation, acc_clr);
    end
  end

  // R5: a write is only issued when there is a stored sample
  a_r5_we_has_data: assert property (@(posedge clk) disable iff (!rst_n)
    mem_we |-> !fifo_empty);

  // R3: a discarded sample raises the overflow flag
  a_r3_drop_sets_ovf: assert property (@(posedge clk) disable iff (!rst_n)
    drop |=> ovf_flag);

  // R4: flags hold until cleared
  a_r4_ovf_sticky: assert property (@(posedge clk) disable iff (!rst_n)
    (ovf_flag && !ovf_clr) |=> ovf_flag);
  a_r4_acc_sticky: assert property (@(posedge clk) disable iff (!rst_n)
    (acc_flag && !acc_clr) |=> acc_flag);

  // R11: collision raises the access-violation flag
  a_r11_acc_set: assert property (@(posedge clk) disable iff (!rst_n)
    (hst_re && mem_we) |=> acc_flag);

  // R12: with the engine on, the host read register does not move
  a_r12_rd_ignored: assert property (@(posedge clk) disable iff (!rst_n)
    !xfer_off |=> $stable(dat_rdata));

  // R9: popping an empty store keeps the last value
  a_r9_empty_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (xfer_off && dat_rd && fifo_empty) |=> $stable(dat_rdata));
endmodule

// File: tb/tb_sxb_top.sv
`timescale 1ns/1ps
module tb_sxb_top;
  localparam int DW = 16;
  localparam int OW = 15;
  localparam int CW = 10;
  localparam int AW = 20;
  localparam logic [AW-1:0] BASE = 20'h0C000;
  localparam logic [DW-1:0] MEMVAL = 16'hA5A5;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic smp_valid = 0, run_en = 0, xfer_off = 0, ofs_wr = 0, cnt_wr = 0;
  logic dat_rd = 0, ovf_clr = 0, acc_clr = 0, hst_re = 0;
  logic [DW-1:0] smp_data = '0;
  logic [OW-1:0] ofs_wdata = '0;
  logic [CW-1:0] cnt_wdata = '0;
  logic [AW-1:0] hst_addr = '0;
  logic [DW-1:0] mem_rdata = MEMVAL;
  logic [OW-1:0] ofs_cur;
  logic [CW-1:0] cnt_left;
  logic [DW-1:0] dat_rdata, mem_wdata, hst_rdata;
  logic ovf_flag, acc_flag, mem_we, mem_re;
  logic [AW-1:0] mem_addr;

  always #4 clk = ~clk;

  sxb_top dut (
    .clk(clk), .rst_n(rst_n), .smp_valid(smp_valid), .smp_data(smp_data),
    .run_en(run_en), .xfer_off(xfer_off), .ofs_wr(ofs_wr), .ofs_wdata(ofs_wdata),
    .ofs_cur(ofs_cur), .cnt_wr(cnt_wr), .cnt_wdata(cnt_wdata), .cnt_left(cnt_left),
    .dat_rd(dat_rd), .dat_rdata(dat_rdata), .ovf_flag(ovf_flag), .ovf_clr(ovf_clr),
    .acc_flag(acc_flag), .acc_clr(acc_clr), .mem_we(mem_we), .mem_re(mem_re),
    .mem_addr(mem_addr), .mem_wdata(mem_wdata), .mem_rdata(mem_rdata),
    .hst_re(hst_re), .hst_addr(hst_addr), .hst_rdata(hst_rdata)
  );

  int checks = 0;
  int errors = 0;
  logic [DW-1:0] exp_q[$];
  int unsigned exp_ofs = 0;

  task automatic chk(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  // expected byte address, stated as arithmetic on integers
  function automatic logic [AW-1:0] want_addr(input int unsigned o);
    return AW'(int'(BASE) + int'((o % 32768) * 2));
  endfunction

  task automatic finish_up();
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  endtask

  task automatic step();
    @(posedge clk);
    #1;
  endtask

  // driver: offer one sample, record it in the scoreboard when a write is expected
  task automatic send(input logic [DW-1:0] d, input bit expect_w);
    smp_valid = 1'b1;
    smp_data  = d;
    if (expect_w) exp_q.push_back(d);
    step();
    smp_valid = 1'b0;
  endtask

  task automatic load_cnt(input int n);
    cnt_wr = 1'b1; cnt_wdata = CW'(n);
    step();
    cnt_wr = 1'b0;
  endtask

  // monitor: scoreboard for engine writes and the shared read port
  always @(negedge clk) begin
    if (rst_n) begin
      if (mem_we) begin
        if (exp_q.size() == 0) begin
          chk(1'b0, "R5 unexpected write", 32'(mem_wdata), 32'hFFFF_FFFF);
        end else begin
          logic [DW-1:0] e;
          e = exp_q.pop_front();
          chk(mem_wdata == e, "R5 write data", 32'(mem_wdata), 32'(e));
          chk(mem_addr == want_addr(exp_ofs), "R6/R7 write address", 32'(mem_addr), 32'(want_addr(exp_ofs)));
          exp_ofs = (exp_ofs + 1) % 32768;
        end
      end
      if (hst_re) begin
        if (mem_we) begin
          chk(hst_rdata == 16'h3FFF, "R11 guard word", 32'(hst_rdata), 32'h3FFF);
          chk(mem_re == 1'b0, "R11 read blocked", 32'(mem_re), 32'h0);
        end else begin
          chk(hst_rdata == MEMVAL && mem_re && mem_addr == hst_addr, "R11 pass-through",
              32'(hst_rdata), 32'(MEMVAL));
        end
      end
    end
  end

  initial begin
    repeat (60000) @(posedge clk);
    errors++;
    $display("FAIL watchdog actual=hung expected=done");
    finish_up();
  end

  initial begin
    repeat (3) step();
    rst_n = 1'b1;
    step();
    // R1 reset state
    chk(ofs_cur == '0, "R1 offset", 32'(ofs_cur), 0);
    chk(cnt_left == '0, "R1 budget", 32'(cnt_left), 0);
    chk(!ovf_flag && !acc_flag, "R1 flags", {ovf_flag, acc_flag}, 0);
    chk(!mem_we && dat_rdata == '0, "R1 idle", 32'(dat_rdata), 0);

    // R13: zero budget accepts nothing
    run_en = 1'b1;
    send(16'hDEAD, 0);
    send(16'hBEEF, 0);
    repeat (3) step();
    chk(!ovf_flag, "R13 no overflow", 32'(ovf_flag), 0);
    chk(ofs_cur == '0, "R13 nothing written", 32'(ofs_cur), 0);

    // R2/R5/R6 engine stream
    load_cnt(10);
    send(16'h1111, 1); send(16'h2222, 1); send(16'h3333, 1); send(16'h4444, 1);
    repeat (3) step();
    chk(cnt_left == 6, "R2 budget after four", 32'(cnt_left), 6);
    chk(ofs_cur == 4, "R6 offset after four", 32'(ofs_cur), 4);
    chk(exp_q.size() == 0, "R5 all written", exp_q.size(), 0);

    // R10/R13: budget runs out, stored samples still drain
    for (int i = 0; i < 8; i++) send(DW'(16'h5000 + i), i < 6);
    repeat (3) step();
    chk(cnt_left == 0, "R10 budget spent", 32'(cnt_left), 0);
    chk(exp_q.size() == 0, "R10 drained", exp_q.size(), 0);
    chk(ofs_cur == 10, "R13 only six written", 32'(ofs_cur), 10);

    // R7 wrap of the offset
    ofs_wr = 1'b1; ofs_wdata = 15'h7FFE;
    step();
    ofs_wr = 1'b0; exp_ofs = 32'h7FFE;
    load_cnt(20);
    send(16'h6001, 1); send(16'h6002, 1); send(16'h6003, 1);
    repeat (3) step();
    chk(ofs_cur == 1, "R7 wrapped offset", 32'(ofs_cur), 1);

    // R8 load beats the increment of a concurrent write
    send(16'h7001, 1);
    ofs_wr = 1'b1; ofs_wdata = 15'h0100;
    step();
    ofs_wr = 1'b0; exp_ofs = 32'h0100;
    chk(ofs_cur == 15'h0100, "R8 load priority", 32'(ofs_cur), 32'h100);

    // R11 collision of engine write and host read
    hst_addr = 20'h0C200;
    send(16'h7002, 1);
    hst_re = 1'b1;
    step();
    hst_re = 1'b0;
    chk(acc_flag, "R11 violation flag", 32'(acc_flag), 1);
    hst_re = 1'b1;
    step();
    hst_re = 1'b0;
    chk(acc_flag, "R4 flag sticky", 32'(acc_flag), 1);
    acc_clr = 1'b1;
    step();
    acc_clr = 1'b0;
    chk(!acc_flag, "R4 flag cleared", 32'(acc_flag), 0);

    // R12 host pops ignored while engine runs
    dat_rd = 1'b1;
    send(16'h7003, 1);
    step();
    dat_rd = 1'b0;
    step();
    chk(dat_rdata == '0, "R12 register unchanged", 32'(dat_rdata), 0);
    chk(exp_q.size() == 0, "R12 sample went to memory", exp_q.size(), 0);

    // R3/R9 host mode: fill, overflow, read back
    xfer_off = 1'b1;
    load_cnt(100);
    for (int i = 0; i < 65; i++) send(DW'(16'h4000 + i), 0);
    run_en = 1'b0;
    step();
    chk(ovf_flag, "R3 overflow flag", 32'(ovf_flag), 1);
    chk(cnt_left == 36, "R3 dropped sample not counted", 32'(cnt_left), 36);
    chk(ofs_cur == 15'h0102, "R9 no writes in host mode", 32'(ofs_cur), 32'h102);
    for (int i = 0; i < 64; i++) begin
      dat_rd = 1'b1;
      step();
      dat_rd = 1'b0;
      chk(dat_rdata == DW'(16'h4000 + i), "R9/R10 host pop order", 32'(dat_rdata), 32'(16'h4000 + i));
    end
    dat_rd = 1'b1;
    step();
    dat_rd = 1'b0;
    chk(dat_rdata == 16'h403F, "R9 empty pop keeps value", 32'(dat_rdata), 32'h403F);
    chk(ovf_flag, "R4 overflow sticky", 32'(ovf_flag), 1);
    ovf_clr = 1'b1;
    step();
    ovf_clr = 1'b0;
    chk(!ovf_flag, "R4 overflow cleared", 32'(ovf_flag), 0);
    chk(exp_q.size() == 0, "R5 scoreboard empty", exp_q.size(), 0);
    finish_up();
  end
endmodule